// File: doc/BRIEF.md
# Hardened Two-Read Register File

This block is a flip-flop register file with one write port and two independent combinational read ports. Its read path is built to survive a single fault-induced bit flip on the select logic. Each binary read address is re-encoded into its own one-hot select vector. A checker verifies that vector, and an AND-OR multiplexer then uses it to pick the read data. A corrupted select therefore cannot quietly return the wrong register. It raises an error instead.

The error comes out in two forms. `fault_o` is combinational and high in the same cycle as the bad select. `alarm_o` is a sticky copy that latches on the next rising clock edge and holds until reset. A system integrator routes these to the chip's fault response.

Setting the parameter `HARDEN` to 0 builds a plain indexed lookup. In that variant both error outputs are tied low. Register 0 is hardwired to zero in both variants.

Top module: `rf_hardened_2r1w`

## Requirements
- R1: When `wr_en_i` is high at a rising edge of `clk`, `wr_data_i` is stored at `wr_addr_i`. Reading that address on either port afterwards returns the value until it is overwritten.
- R2: Register 0 always reads as zero on both ports, and a write to address 0 has no effect.
- R3: A low level on `rst_n` clears every register and `alarm_o` at once, without waiting for a clock edge.
- R4: Read address 0 produces a select vector with only bit 0 set and raises no fault.
- R5: If any single bit of port A's one-hot select vector flips, `fault_o` goes high in the same cycle. A flip can leave no bit set or two bits set.
- R6: If any single bit of port B's select vector flips, `fault_o` goes high as well. `fault_o` is the OR of the errors from both ports.
- R7: If the select vector has exactly one bit set, but at a position other than the binary read address, `fault_o` goes high.
- R8: `alarm_o` goes high at the first rising edge at which `fault_o` is high. It then stays high until reset, even after the fault is gone.
- R9: With no fault present, `fault_o` and `alarm_o` stay low for every read address on both ports.
- R10: With `HARDEN` = 0, read data comes from an indexed lookup and follows R1 and R2, while `fault_o` and `alarm_o` are constant low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and alarm updates happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_a_i | input | ADDR_W | Read address, port A |
| rd_data_a_o | output | DATA_W | Read data, port A (combinational) |
| rd_addr_b_i | input | ADDR_W | Read address, port B |
| rd_data_b_o | output | DATA_W | Read data, port B (combinational) |
| fault_o | output | 1 | Same-cycle select-vector error, both ports combined |
| alarm_o | output | 1 | Sticky error, cleared only by reset |

## Verification
The assertions tie register-0 reads and clean select vectors to the state of `fault_o`. A read that happens while a select vector is corrupted therefore has no data expectation. They also assume a write lands at the edge it is issued on, so a value written at one edge is visible one cycle later.

The stimulus keeps addresses and write controls stable between edges, changing them just after a rising edge. Corrupted select vectors are forced for exactly one cycle and then released. A reset follows each injection, because the alarm never clears by itself.

// File: rtl/rfh_pkg.sv
package rfh_pkg;
  // Default geometry shared by the register file and its helpers.
  localparam int unsigned RFH_ADDR_W = 5;
  localparam int unsigned RFH_DATA_W = 32;
endpackage

// File: rtl/rfh_addr_enc.sv
// Binary-to-one-hot encoder for one read address.
module rfh_addr_enc #(
  parameter int unsigned ADDR_W = rfh_pkg::RFH_ADDR_W,
  localparam int unsigned N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N-1:0]      oh_o
);
  for (genvar i = 0; i < N; i++) begin : gen_bit
    assign oh_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/rfh_oh_check.sv
// Checks a select vector: exactly one bit set (when enabled), and that bit
// re-encoded to binary must equal the address that produced it.
module rfh_oh_check #(
  parameter int unsigned ADDR_W = rfh_pkg::RFH_ADDR_W,
  localparam int unsigned N = 1 << ADDR_W
) (
  input  logic [N-1:0]      oh_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              err_o
);
  logic              none_set;
  logic              many_set;
  logic [ADDR_W-1:0] back_addr;
  logic              addr_mismatch;

  always_comb begin
    back_addr = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_i[i]) back_addr = back_addr | ADDR_W'(i);
    end
  end

  assign none_set      = ~|oh_i;
  assign many_set      = |(oh_i & (oh_i - N'(1)));
  assign addr_mismatch = (back_addr != addr_i);
  // The address test is only meaningful together with the enable test.
  assign err_o = en_i ? (none_set | many_set | addr_mismatch) : (|oh_i);
endmodule

// File: rtl/rfh_oh_mux.sv
// AND-OR multiplexer driven by a one-hot select vector.
module rfh_oh_mux #(
  parameter int unsigned N      = 32,
  parameter int unsigned DATA_W = rfh_pkg::RFH_DATA_W
) (
  input  logic [N-1:0][DATA_W-1:0] din_i,
  input  logic [N-1:0]             sel_i,
  output logic [DATA_W-1:0]        dout_o
);
  always_comb begin
    dout_o = '0;
    for (int i = 0; i < N; i++) begin
      dout_o = dout_o | (din_i[i] & {DATA_W{sel_i[i]}});
    end
  end
endmodule

// File: rtl/rf_hardened_2r1w.sv
module rf_hardened_2r1w #(
  parameter int unsigned ADDR_W = rfh_pkg::RFH_ADDR_W,
  parameter int unsigned DATA_W = rfh_pkg::RFH_DATA_W,
  parameter bit          HARDEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  output logic              fault_o,
  output logic              alarm_o
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  // Storage: entry 0 is only ever written by reset, so it stays zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en_i && (wr_addr_i != '0)) begin
      regs[wr_addr_i] <= wr_data_i;
    end
  end

  if (HARDEN) begin : gen_hard
    logic [NUM_REGS-1:0] sel_a;
    logic [NUM_REGS-1:0] sel_b;
    logic                err_a;
    logic                err_b;
    logic                alarm_q;

    rfh_addr_enc #(.ADDR_W(ADDR_W)) u_enc_a (.addr_i(rd_addr_a_i), .oh_o(sel_a));
    rfh_addr_enc #(.ADDR_W(ADDR_W)) u_enc_b (.addr_i(rd_addr_b_i), .oh_o(sel_b));

    // Encoders never idle, so the enable of each check is held active.
    rfh_oh_check #(.ADDR_W(ADDR_W)) u_chk_a (
      .oh_i(sel_a), .addr_i(rd_addr_a_i), .en_i(1'b1), .err_o(err_a));
    rfh_oh_check #(.ADDR_W(ADDR_W)) u_chk_b (
      .oh_i(sel_b), .addr_i(rd_addr_b_i), .en_i(1'b1), .err_o(err_b));

    rfh_oh_mux #(.N(NUM_REGS), .DATA_W(DATA_W)) u_mux_a (
      .din_i(regs), .sel_i(sel_a), .dout_o(rd_data_a_o));
    rfh_oh_mux #(.N(NUM_REGS), .DATA_W(DATA_W)) u_mux_b (
      .din_i(regs), .sel_i(sel_b), .dout_o(rd_data_b_o));

    assign fault_o = err_a | err_b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       alarm_q <= 1'b0;
      else if (fault_o) alarm_q <= 1'b1;
    end
    assign alarm_o = alarm_q;

    AST_CLEAN_SEL_A: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> ($countones(sel_a) == 1 && sel_a[rd_addr_a_i])); // R5
    AST_CLEAN_SEL_B: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> ($countones(sel_b) == 1 && sel_b[rd_addr_b_i])); // R6
    AST_ADDR0_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a_i == '0 && !fault_o) |-> (sel_a == NUM_REGS'(1))); // R4
    AST_FAULT_ARMS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> alarm_o); // R8
    AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |=> alarm_o); // R8
    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a_i == '0 && !fault_o) |-> (rd_data_a_o == '0)); // R2
    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i != '0) |=>
        ((rd_addr_b_i != $past(wr_addr_i)) || fault_o ||
         (rd_data_b_o == $past(wr_data_i)))); // R1
  end else begin : gen_plain
    assign rd_data_a_o = regs[rd_addr_a_i];
    assign rd_data_b_o = regs[rd_addr_b_i];
    assign fault_o     = 1'b0;
    assign alarm_o     = 1'b0;

    AST_PLAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o && !alarm_o); // R10
    AST_PLAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a_i == '0) |-> (rd_data_a_o == '0)); // R2
  end
endmodule

// File: tb/test_rf_hardened_2r1w.sv
module test_rf_hardened_2r1w;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 32;
  localparam int unsigned N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] ra = '0;
  logic [AW-1:0] rb = '0;
  logic [DW-1:0] da, db, pda, pdb;
  logic          fault, alarm, pfault, palarm;
  logic [N-1:0]  fvec = '0;

  always #5 clk = ~clk;

  rf_hardened_2r1w #(.ADDR_W(AW), .DATA_W(DW), .HARDEN(1'b1)) i_rf_hardened_2r1w (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_a_i(ra), .rd_data_a_o(da),
    .rd_addr_b_i(rb), .rd_data_b_o(db), .fault_o(fault), .alarm_o(alarm));

  rf_hardened_2r1w #(.ADDR_W(AW), .DATA_W(DW), .HARDEN(1'b0)) i_rf_plain (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_a_i(ra), .rd_data_a_o(pda),
    .rd_addr_b_i(rb), .rd_data_b_o(pdb), .fault_o(pfault), .alarm_o(palarm));

  typedef struct {
    string         req;
    logic          chk_data;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
    logic          ef;
    logic          eal;
  } item_t;

  item_t         sb_q[$];
  logic [DW-1:0] model [N];
  logic          alarm_exp = 1'b0;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  task automatic cmp(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input string req, input logic chk, input logic ef);
    item_t it;
    it.req = req; it.chk_data = chk; it.ea = model[ra]; it.eb = model[rb];
    it.ef = ef; it.eal = alarm_exp;
    sb_q.push_back(it);
  endtask

  // Monitor: pops one expected item per cycle, sampled mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk_data) begin
          cmp(it.req, "rdata_a", da, it.ea);
          cmp(it.req, "rdata_b", db, it.eb);
        end
        cmp(it.req, "fault", {31'b0, fault}, {31'b0, it.ef});
        cmp(it.req, "alarm", {31'b0, alarm}, {31'b0, it.eal});
        cmp({it.req, " R10"}, "plain rdata_a", pda, it.ea);
        cmp({it.req, " R10"}, "plain rdata_b", pdb, it.eb);
        cmp("R10", "plain fault/alarm", {30'b0, pfault, palarm}, '0);
      end
    end
  end

  task automatic read2(input logic [AW-1:0] a, input logic [AW-1:0] b, input string req);
    @(posedge clk); #1;
    wr_en = 1'b0; ra = a; rb = b;
    push(req, 1'b1, 1'b0);
  endtask

  task automatic write1(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a != '0) model[a] = d;
  endtask

  task automatic do_reset(input string req);
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) model[i] = '0;
    alarm_exp = 1'b0;
    push(req, 1'b1, 1'b0);   // cleared before any clock edge
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  // Drive a corrupted select vector for one cycle, then release it.
  task automatic inject(input bit port_b, input logic [AW-1:0] a,
                        input logic [N-1:0] vec, input string req);
    @(posedge clk); #1;
    wr_en = 1'b0; ra = a; rb = a; fvec = vec;
    if (port_b) force i_rf_hardened_2r1w.gen_hard.sel_b = fvec;
    else        force i_rf_hardened_2r1w.gen_hard.sel_a = fvec;
    push(req, 1'b0, 1'b1);
    @(posedge clk); #1;
    if (port_b) release i_rf_hardened_2r1w.gen_hard.sel_b;
    else        release i_rf_hardened_2r1w.gen_hard.sel_a;
    alarm_exp = 1'b1;
    push("R8 sticky after release", 1'b1, 1'b0);
    read2(a + 1, a, "R8 still latched");
    do_reset("R3 alarm cleared");
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    #22 rst_n = 1'b1;
    read2(0, 31, "R3 reset contents");
    read2(5, 17, "R3 reset contents");
    // Fill every entry, including the hardwired one.
    for (int i = 0; i < N; i++) write1(AW'(i), 32'hC0DE_0000 ^ (i * 32'h0101_0101) ^ 32'h5A);
    for (int i = 0; i < N; i++) read2(AW'(i), AW'(N - 1 - i), "R1/R9 full sweep");
    read2(0, 0, "R2 R4 zero entry");
    write1(0, 32'hFFFF_FFFF);
    read2(0, 0, "R2 write to zero ignored");
    write1(9, 32'h1234_5678);
    read2(9, 9, "R1 overwrite");
    write1(9, 32'h0BAD_F00D);
    read2(3, 9, "R1 second overwrite");
    // Faults.
    inject(1'b0, 7, (N'(1) << 7) ^ (N'(1) << 3), "R5 flip adds bit");
    write1(4, 32'h4444_0004);
    inject(1'b0, 7, '0, "R5 flip clears bit");
    inject(1'b0, 0, N'(3), "R5 flip on zero entry");
    inject(1'b1, 12, (N'(1) << 12) ^ N'(1), "R6 port B flip");
    inject(1'b1, 31, (N'(1) << 31) ^ (N'(1) << 30), "R6 port B top bit");
    inject(1'b0, 7, N'(1) << 9, "R7 wrong position");
    write1(20, 32'h2020_2020);
    read2(20, 0, "R9 clean after faults");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule